// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit integer arithmetic and logic unit that works on packed lanes. A run-time size select divides each 64-bit operand into one 64-bit, two 32-bit, four 16-bit or eight 8-bit elements. A single operation then acts on every element in parallel. Add and subtract break their carry and borrow chain at each lane edge. Each lane can also clamp its own result to a signed or unsigned range instead of wrapping. Bitwise AND, OR and XOR act on the whole 64-bit word as one.

The block has one register stage. The operands, size, opcode and overflow mode presented before a rising clock edge produce the result, which appears on the output after that edge and stays there until the next edge. An asynchronous active-low reset clears the result register.

Top module: `packed_lane_alu`

## Requirements
- R1: While reset is low the result reads zero. Otherwise the result after each rising edge is the function of the inputs sampled at that edge, so there is exactly one cycle of latency.
- R2: Add (opcode 0) and subtract (opcode 1) in wrap mode act on each lane alone. The lane width is set by the size code: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. A lane keeps the low bits of its own sum, and no carry or borrow enters the next lane. Overflow mode 0 and the unused mode code 3 both wrap.
- R3: With overflow mode 1 and 8- or 16-bit lanes, a lane whose signed result would overflow is clamped. A result that would pass the positive limit gives the lane's largest positive value (0x7F or 0x7FFF). A result that would pass the negative limit gives the most negative value (0x80 or 0x8000).
- R4: With overflow mode 2 and 8- or 16-bit lanes, an unsigned add that carries out of a lane gives all ones in that lane. An unsigned subtract that borrows gives zero in that lane.
- R5: With 32- or 64-bit lanes, overflow modes 1 and 2 have no effect and the result wraps as in R2.
- R6: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of the full 64-bit operands. The size select and the overflow mode have no effect on them.
- R7: Opcodes 5 to 7 are not assigned and give a zero result.
- R8: With size code 3, add and subtract carry across all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opa_i | input | 64 | First operand (minuend for subtract) |
| opb_i | input | 64 | Second operand (subtrahend for subtract) |
| lane_size_i | input | 2 | Element size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| op_i | input | 3 | 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, others give zero |
| sat_mode_i | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 wrap |
| result_o | output | 64 | Registered result |

## Verification
The risky case is a cycle in which one lane overflows while its neighbour must not see that overflow. The first lane has to clamp, or drop its carry, and the lane above must still compute from its own bits alone. The stimulus places values such as 0xFF + 0x01 and 0x7F + 0x01 next to small lanes in one vector. It then applies that same vector in wrap, signed and unsigned modes and at every size. Each lane's expected value is worked out by hand from the lane arithmetic, so a carry that leaks into the next lane, or a clamp taken from the wrong byte of a 16-bit lane, shows up as a single-lane mismatch.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2,
        SZ_Q = 2'd3
    } lane_size_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SAT_WRAP     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2
    } sat_mode_e;

endpackage

// File: rtl/seg_adder.sv
// Slice-based adder: one SLICE_W-bit adder per slice. A slice that starts a
// lane takes the subtract flag as its carry-in instead of the neighbour carry.
module seg_adder #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0]         opa_i,
    input  logic [DATA_W-1:0]         opb_i,
    input  logic [1:0]                lane_size_i,
    input  logic                      sub_i,
    output logic [DATA_W-1:0]         sum_o,
    output logic [DATA_W/SLICE_W-1:0] slice_cout_o
);
    localparam int NS = DATA_W / SLICE_W;

    logic [DATA_W-1:0] opb_eff;
    logic [NS-1:0]     lane_start;
    logic [NS:0]       carry;
    int unsigned       lane_mask;

    assign opb_eff  = sub_i ? ~opb_i : opb_i;
    assign carry[0] = sub_i;

    always_comb begin
        lane_mask = (32'd1 << lane_size_i) - 32'd1;
        for (int i = 0; i < NS; i++) begin
            lane_start[i] = ((32'(i) & lane_mask) == 32'd0);
        end
    end

    for (genvar g = 0; g < NS; g++) begin : g_slice
        logic           cin;
        logic [SLICE_W:0] tot;
        assign cin = lane_start[g] ? sub_i : carry[g];
        assign tot = {1'b0, opa_i[g*SLICE_W +: SLICE_W]}
                   + {1'b0, opb_eff[g*SLICE_W +: SLICE_W]}
                   + {{SLICE_W{1'b0}}, cin};
        assign sum_o[g*SLICE_W +: SLICE_W] = tot[SLICE_W-1:0];
        assign carry[g+1] = tot[SLICE_W];
    end

    assign slice_cout_o = carry[NS:1];

endmodule

// File: rtl/lane_clamp.sv
// Per-slice saturation. In 16-bit mode a slice reads the overflow condition
// from the upper slice of its pair (NS must be even).
module lane_clamp
    import simd_alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0]         sum_i,
    input  logic [DATA_W/SLICE_W-1:0] slice_cout_i,
    input  logic [DATA_W/SLICE_W-1:0] a_sign_i,
    input  logic [DATA_W/SLICE_W-1:0] b_sign_i,
    input  logic                      pair_mode_i,
    input  logic                      sub_i,
    input  logic                      sat_en_i,
    input  logic [1:0]                sat_mode_i,
    output logic [DATA_W-1:0]         res_o
);
    localparam int NS = DATA_W / SLICE_W;

    logic sat_signed;
    logic sat_unsigned;

    assign sat_signed   = sat_en_i && (sat_mode_i == SAT_SIGNED);
    assign sat_unsigned = sat_en_i && (sat_mode_i == SAT_UNSIGNED);

    for (genvar g = 0; g < NS; g++) begin : g_clamp
        localparam int TW = g | 1;
        logic               sa, sb, sr, co, is_top, s_ovf, u_ovf;
        logic [SLICE_W-1:0] raw, max_v, min_v, slice_res;

        assign raw    = sum_i[g*SLICE_W +: SLICE_W];
        assign is_top = pair_mode_i ? (g == TW) : 1'b1;
        assign sa     = pair_mode_i ? a_sign_i[TW] : a_sign_i[g];
        assign sb     = (pair_mode_i ? b_sign_i[TW] : b_sign_i[g]) ^ sub_i;
        assign sr     = pair_mode_i ? sum_i[TW*SLICE_W + SLICE_W-1]
                                    : sum_i[g*SLICE_W + SLICE_W-1];
        assign co     = pair_mode_i ? slice_cout_i[TW] : slice_cout_i[g];
        assign s_ovf  = (sa == sb) && (sr != sa);
        assign u_ovf  = co ^ sub_i;
        assign max_v  = is_top ? {1'b0, {(SLICE_W-1){1'b1}}} : {SLICE_W{1'b1}};
        assign min_v  = is_top ? {1'b1, {(SLICE_W-1){1'b0}}} : {SLICE_W{1'b0}};

        always_comb begin
            slice_res = raw;
            if (sat_signed && s_ovf) begin
                slice_res = sa ? min_v : max_v;
            end else if (sat_unsigned && u_ovf) begin
                slice_res = sub_i ? {SLICE_W{1'b0}} : {SLICE_W{1'b1}};
            end
        end

        assign res_o[g*SLICE_W +: SLICE_W] = slice_res;
    end

endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [2:0]        op_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        case (op_i)
            OP_AND:  res_o = opa_i & opb_i;
            OP_OR:   res_o = opa_i | opb_i;
            OP_XOR:  res_o = opa_i ^ opb_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [1:0]        lane_size_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        sat_mode_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int NS = DATA_W / SLICE_W;

    typedef struct packed {
        logic [DATA_W-1:0] result;
    } state_t;

    state_t st_d, st_q;

    logic              is_sub, is_arith, sat_en;
    logic [DATA_W-1:0] sum, arith_res, logic_res;
    logic [NS-1:0]     slice_cout, a_sign, b_sign;

    assign is_sub   = (op_i == OP_SUB);
    assign is_arith = (op_i == OP_ADD) || is_sub;
    assign sat_en   = is_arith && ((lane_size_i == SZ_B) || (lane_size_i == SZ_W));

    for (genvar g = 0; g < NS; g++) begin : g_sign
        assign a_sign[g] = opa_i[g*SLICE_W + SLICE_W-1];
        assign b_sign[g] = opb_i[g*SLICE_W + SLICE_W-1];
    end

    seg_adder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_adder (
        .opa_i        (opa_i),
        .opb_i        (opb_i),
        .lane_size_i  (lane_size_i),
        .sub_i        (is_sub),
        .sum_o        (sum),
        .slice_cout_o (slice_cout)
    );

    lane_clamp #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_clamp (
        .sum_i        (sum),
        .slice_cout_i (slice_cout),
        .a_sign_i     (a_sign),
        .b_sign_i     (b_sign),
        .pair_mode_i  (lane_size_i == SZ_W),
        .sub_i        (is_sub),
        .sat_en_i     (sat_en),
        .sat_mode_i   (sat_mode_i),
        .res_o        (arith_res)
    );

    bitwise_unit #(.DATA_W(DATA_W)) u_logic (
        .opa_i (opa_i),
        .opb_i (opb_i),
        .op_i  (op_i),
        .res_o (logic_res)
    );

    always_comb begin
        st_d = st_q;
        if (is_arith) begin
            st_d.result = arith_res;
        end else begin
            st_d.result = logic_res;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;

endmodule

// File: rtl/packed_lane_alu_chk.sv
module packed_lane_alu_chk #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [1:0]        lane_size_i,
    input logic [2:0]        op_i,
    input logic [1:0]        sat_mode_i,
    input logic [DATA_W-1:0] result_o
);
    localparam int NS = DATA_W / SLICE_W;

    function automatic logic slices_not_below(input logic [DATA_W-1:0] r,
                                              input logic [DATA_W-1:0] a);
        logic ok = 1'b1;
        for (int i = 0; i < NS; i++) begin
            if (r[i*SLICE_W +: SLICE_W] < a[i*SLICE_W +: SLICE_W]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic no_pos_wrap(input logic [DATA_W-1:0] r,
                                         input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b);
        logic ok = 1'b1;
        for (int i = 0; i < NS; i++) begin
            if (!a[i*SLICE_W + SLICE_W-1] && !b[i*SLICE_W + SLICE_W-1]
                && r[i*SLICE_W + SLICE_W-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (result_o == '0));

    p_dword_isolated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd0 && lane_size_i == 2'd2)
        |=> (result_o[DATA_W/2-1:0] == $past(opa_i[DATA_W/2-1:0]) + $past(opb_i[DATA_W/2-1:0])));

    p_signed_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd0 && lane_size_i == 2'd0 && sat_mode_i == 2'd1)
        |=> no_pos_wrap(result_o, $past(opa_i), $past(opb_i)));

    p_unsigned_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd0 && lane_size_i == 2'd0 && sat_mode_i == 2'd2)
        |=> slices_not_below(result_o, $past(opa_i)));

    p_bitwise_and_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd2) |=> (result_o == ($past(opa_i) & $past(opb_i))));

    p_bad_op_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i > 3'd4) |=> (result_o == '0));

    p_quad_add_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd0 && lane_size_i == 2'd3)
        |=> (result_o == $past(opa_i) + $past(opb_i)));

endmodule

bind packed_lane_alu packed_lane_alu_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/packed_lane_alu_bench.sv
module packed_lane_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [1:0]  lsz = '0;
    logic [2:0]  op = '0;
    logic [1:0]  smode = '0;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    packed_lane_alu u_packed_lane_alu (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .opa_i       (opa),
        .opb_i       (opb),
        .lane_size_i (lsz),
        .op_i        (op),
        .sat_mode_i  (smode),
        .result_o    (result)
    );

    localparam int NV = 22;
    localparam logic [63:0] A1 = 64'h01FF_7F80_0102_0304;
    localparam logic [63:0] B1 = 64'h0101_0180_FF01_0101;
    localparam logic [63:0] A2 = 64'h0080_7F00_1000_FF05;
    localparam logic [63:0] B2 = 64'h0101_FF01_2001_0106;
    localparam logic [63:0] A3 = 64'hF0F0_FF00_1234_5678;
    localparam logic [63:0] B3 = 64'hFF00_0F0F_FFFF_0000;

    localparam logic [63:0] VA [NV] = '{
        A1, A1, A1, A1, A1, A1, A1, A1, A1,
        A2, A2, A2, A2, A2, 64'h0, 64'h0,
        A3, A3, A3, A3, 64'h0000_0005_0000_0000, 64'h7F };
    localparam logic [63:0] VB [NV] = '{
        B1, B1, B1, B1, B1, B1, B1, B1, B1,
        B2, B2, B2, B2, B2, 64'h1, 64'h1,
        B3, B3, B3, B3, 64'h0000_0001_0000_0001, 64'h01 };
    localparam logic [1:0] VS [NV] = '{
        2'd0, 2'd3, 2'd1, 2'd2, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2,
        2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd3, 2'd3,
        2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd0 };
    localparam logic [2:0] VO [NV] = '{
        3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0,
        3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1,
        3'd2, 3'd3, 3'd4, 3'd5, 3'd1, 3'd0 };
    localparam logic [1:0] VM [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1,
        2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd0, 2'd2,
        2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd3 };
    localparam logic [63:0] VE [NV] = '{
        64'h0200_8000_0003_0405,  // R2 bytes wrap add
        64'h0300_8101_0003_0405,  // R8 quad add, carry crosses all bytes
        64'h0300_8100_0003_0405,  // R2 words wrap add
        64'h0300_8100_0003_0405,  // R2 dwords wrap add
        64'h0200_7F80_0003_0405,  // R3 bytes signed clamp add
        64'h02FF_80FF_FF03_0405,  // R4 bytes unsigned clamp add
        64'h0300_7FFF_0003_0405,  // R3 words signed clamp add
        64'h0300_8100_FFFF_0405,  // R4 words unsigned clamp add
        64'h0300_8100_0003_0405,  // R5 dwords signed mode wraps
        64'hFF7F_80FF_F0FF_FEFF,  // R2 bytes wrap sub
        64'hFF80_7FFF_F0FF_FEFF,  // R3 bytes signed clamp sub
        64'h007F_0000_0000_FE00,  // R4 bytes unsigned clamp sub
        64'hFF7F_7FFF_EFFF_FDFF,  // R3 words signed sub, edge 0x7FFF exact
        64'h0000_0000_0000_FDFF,  // R4 words unsigned clamp sub
        64'hFFFF_FFFF_FFFF_FFFF,  // R8 quad borrow across all bytes
        64'hFFFF_FFFF_FFFF_FFFF,  // R5 quad unsigned mode wraps
        64'hF000_0F00_1234_0000,  // R6 AND
        64'hFFF0_FF0F_FFFF_5678,  // R6 OR
        64'h0FF0_F00F_EDCB_5678,  // R6 XOR
        64'h0,                    // R7 unused opcode
        64'h0000_0004_FFFF_FFFF,  // R2 dword borrow stays in lane
        64'h80 };                 // R2 mode code 3 wraps
    localparam int VR [NV] = '{2, 8, 2, 2, 3, 4, 3, 4, 5, 2, 3, 4, 3, 4, 8, 5,
                               6, 6, 6, 7, 2, 2};

    task automatic check(input logic [63:0] got, input logic [63:0] exp,
                         input int req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] s, input logic [2:0] o, input logic [1:0] m);
        opa = a; opb = b; lsz = s; op = o; smode = m;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(result, 64'h0, 1, "reset state");             // R1
        rst_n = 1'b1;
        @(negedge clk);
        check(result, 64'h0, 1, "idle after reset");         // R1 (add 0+0)

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VA[i], VB[i], VS[i], VO[i], VM[i]);
            @(negedge clk);
            check(result, VE[i], VR[i], $sformatf("vector %0d", i));
        end

        // R1 latency: new inputs do not show before the edge
        @(negedge clk);
        drive(64'h1, 64'h2, 2'd3, 3'd0, 2'd0);
        @(negedge clk);
        check(result, 64'h3, 1, "first result");
        drive(64'h10, 64'h20, 2'd3, 3'd0, 2'd0);
        #1;
        check(result, 64'h3, 1, "held before edge");
        @(negedge clk);
        check(result, 64'h30, 1, "updated after edge");

        // R6 bitwise ignores size and mode: same operands, other size/mode
        drive(A3, B3, 2'd3, 3'd2, 2'd2);
        @(negedge clk);
        check(result, 64'hF000_0F00_1234_0000, 6, "AND with quad size, unsigned mode");

        // R3 most negative word clamp: 0x8000 + 0xFFFF in every lane
        drive(64'h8000_8000_8000_8000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 3'd0, 2'd1);
        @(negedge clk);
        check(result, 64'h8000_8000_8000_8000, 3, "word negative clamp");

        // R4 unsigned byte clamp in alternating lanes, neighbours untouched
        drive(64'hFF01_FF01_FF01_FF01, 64'h0101_0101_0101_0101, 2'd0, 3'd0, 2'd2);
        @(negedge clk);
        check(result, 64'hFF02_FF02_FF02_FF02, 4, "alternating byte clamp");

        // R1 asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        check(result, 64'h0, 1, "async reset clears");
        @(negedge clk);
        rst_n = 1'b1;
        drive('0, '0, 2'd0, 3'd0, 2'd0);
        @(negedge clk);
        check(result, 64'h0, 1, "after second reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule